// File: doc/BRIEF.md
# 2x Nearest-Neighbour Row Upsampler

This block doubles the size of one channel of a feature map. Elements arrive one per valid cycle in row-major order. Each element is stored at its own location in an internal RAM. The block then produces a stream twice as wide and twice as tall, also in row-major order. An input of W x H elements gives an output of 2W x 2H elements, so an 8x8 input becomes 16x16.

The upscaling comes only from how the RAM addresses are replayed:

- Every address is read on two consecutive read cycles.
- When the end of a row has been reached, the read pointer goes back to the start of that same row, so the doubled row is sent a second time.
- The read pointer then moves on by one image width to the next row.

The write side arms the read side once the first complete row is stored. A row is never read before all of its elements have been written; until then the output simply stalls. A `clear` input restarts the whole frame. A single-cycle `out_done` marks the last output element.

Top module: `up2x_row`

## Requirements
- R1: For a W x H input frame, exactly 4*W*H output elements appear with `out_valid` high, and then no more until the next `clear`.
- R2: Within an output row, each stored element appears twice on consecutive output elements, in input column order.
- R3: Each doubled row is emitted twice in a row, and output rows follow input row order.
- R4: `out_valid` stays low while fewer than W elements of the frame have been accepted.
- R5: When the next input row is not yet complete, output stalls with `out_valid` low and later resumes in the correct order. `out_done` is raised only after all H rows have been written.
- R6: `out_done` is high for exactly one cycle per frame, in the same cycle as the last output element.
- R7: `clear` drives `out_valid` and `out_done` low on the next cycle. It restarts writing and reading at RAM address 0, so the next frame is output correctly even after a frame was cut off midway.
- R8: Input elements presented after W*H elements have been accepted are ignored until the next `clear`. They produce no output.
- R9: The write address and the read row base both wrap modulo RAM_DEPTH. A frame larger than the RAM is output correctly when the input pacing keeps writes from overtaking reads.
- R10: After reset, `out_valid` and `out_done` are low.
- R11: RAM read latency is one cycle. The first output element appears two clock edges after the edge that accepts the last element of the first row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clear | input | 1 | Start of a new frame: resets all counters and addresses to zero |
| in_data | input | ELEM_W | Input element |
| in_valid | input | 1 | Input element is valid this cycle |
| out_data | output | ELEM_W | Output element |
| out_valid | output | 1 | Output element is valid this cycle |
| out_done | output | 1 | One-cycle pulse with the last output element of the frame |

## Verification
The checker assumes the source never writes a row into RAM locations that still hold a row not yet fully replayed. With the RAM smaller than the frame, that is only a pacing condition on `in_valid`. The bench uses a 4x6 image with a 16-entry RAM, which forces address wrap. It feeds data in three patterns: one element every four cycles, whole rows in bursts followed by idle time, and a slow trickle that makes the reader stall. In every pattern the input never runs more than three rows ahead of the reader. The bench also assumes `clear` is the only way a new frame begins, so it always clears before sending a frame.

// File: rtl/up2x_pkg.sv
// Shared types and helpers for the 2x row upsampler.
// Assumes all operands of wrap_sum are below the wrap modulus.
package up2x_pkg;

    // Read controller phases: waiting for first row, streaming, frame finished
    typedef enum logic [1:0] {
        RS_ARMED  = 2'd0,
        RS_STREAM = 2'd1,
        RS_FINISH = 2'd2
    } rd_state_t;

    // Addition modulo 'modulus', valid when a < modulus and b <= modulus
    function automatic int unsigned wrap_sum(int unsigned a, int unsigned b,
                                             int unsigned modulus);
        int unsigned s;
        s = a + b;
        return (s >= modulus) ? (s - modulus) : s;
    endfunction

endpackage

// File: rtl/up2x_ram.sv
// Simple dual-port RAM: one write port, one read port with a registered
// output (one cycle read latency). Assumes no same-address read/write
// collision is relied upon by the user.
module up2x_ram #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 64,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [DEPTH];

    // Store one element per location
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Registered read
    always_ff @(posedge clk) begin
        if (re) begin
            rdata <= mem[raddr];
        end
    end

endmodule

// File: rtl/up2x_wr_ctrl.sv
// Write controller: places each accepted element at the next RAM address
// (wrapping modulo DEPTH), counts completed rows and pulses first_row when
// the first full row of the frame has been stored. Elements beyond one
// frame are refused until clear. Assumes IMG_W >= 2.
module up2x_wr_ctrl #(
    parameter int IMG_W  = 8,
    parameter int IMG_H  = 8,
    parameter int DEPTH  = 64,
    localparam int AW    = $clog2(DEPTH),
    localparam int COL_W = $clog2(IMG_W),
    localparam int ROW_W = $clog2(IMG_H + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             in_valid,
    output logic             we,
    output logic [AW-1:0]    wr_addr,
    output logic [ROW_W-1:0] rows_written,
    output logic             first_row
);

    localparam logic [COL_W-1:0] COL_LAST = COL_W'(IMG_W - 1);
    localparam logic [ROW_W-1:0] ROW_ALL  = ROW_W'(IMG_H);
    localparam logic [AW-1:0]    ADDR_TOP = AW'(DEPTH - 1);

    logic [COL_W-1:0] wr_col;
    logic             row_end;

    // Accept only while the frame is incomplete
    assign we      = in_valid && !clear && (rows_written != ROW_ALL);
    assign row_end = we && (wr_col == COL_LAST);

    // Advance write address, column and completed-row count
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wr_addr      <= '0;
            wr_col       <= '0;
            rows_written <= '0;
            first_row    <= 1'b0;
        end else begin
            first_row <= row_end && (rows_written == '0);
            if (we) begin
                wr_addr <= (wr_addr == ADDR_TOP) ? '0 : wr_addr + 1'b1;
                wr_col  <= row_end ? '0 : wr_col + 1'b1;
            end
            if (row_end) begin
                rows_written <= rows_written + 1'b1;
            end
        end
    end

endmodule

// File: rtl/up2x_rd_ctrl.sv
// Read controller: replays each stored element twice and each row twice
// by address control. Waits for first_row, then reads row r only while
// more than r rows are complete. Produces read enable/address and the
// output valid/done, each delayed one cycle to match RAM latency.
// Assumes IMG_W >= 2 and IMG_W <= DEPTH.
module up2x_rd_ctrl #(
    parameter int IMG_W  = 8,
    parameter int IMG_H  = 8,
    parameter int DEPTH  = 64,
    localparam int AW    = $clog2(DEPTH),
    localparam int COL_W = $clog2(IMG_W),
    localparam int ROW_W = $clog2(IMG_H + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             first_row,
    input  logic [ROW_W-1:0] rows_written,
    output logic             rd_en,
    output logic [AW-1:0]    rd_addr,
    output logic [ROW_W-1:0] rd_row,
    output logic             out_valid,
    output logic             out_done
);

    import up2x_pkg::*;

    localparam logic [COL_W-1:0] COL_LAST = COL_W'(IMG_W - 1);
    localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(IMG_H - 1);

    rd_state_t        state;
    logic [COL_W-1:0] col;
    logic [AW-1:0]    base;
    logic             rep_elem;
    logic             rep_row;
    logic             active;
    logic             last_read;

    // Read is allowed once armed and the current row is fully stored
    assign active  = (state == RS_STREAM) || (state == RS_ARMED && first_row);
    assign rd_en   = active && !clear && (rows_written > rd_row);
    assign rd_addr = AW'(wrap_sum(32'(base), 32'(col), DEPTH));

    // Final read of the frame: second copy, last column, second row pass
    assign last_read = rep_elem && rep_row && (col == COL_LAST) &&
                       (rd_row == ROW_LAST);

    // Phase tracking and position counters
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            state    <= RS_ARMED;
            col      <= '0;
            base     <= '0;
            rd_row   <= '0;
            rep_elem <= 1'b0;
            rep_row  <= 1'b0;
        end else begin
            if (state == RS_ARMED && first_row) begin
                state <= RS_STREAM;
            end
            if (rd_en) begin
                rep_elem <= !rep_elem;
                if (rep_elem) begin
                    if (col != COL_LAST) begin
                        col <= col + 1'b1;
                    end else begin
                        col     <= '0;
                        rep_row <= !rep_row;
                        if (rep_row) begin
                            rd_row <= rd_row + 1'b1;
                            base   <= AW'(wrap_sum(32'(base), 32'(IMG_W), DEPTH));
                            if (rd_row == ROW_LAST) begin
                                state <= RS_FINISH;
                            end
                        end
                    end
                end
            end
        end
    end

    // Delay valid and done by the RAM read latency
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            out_valid <= 1'b0;
            out_done  <= 1'b0;
        end else begin
            out_valid <= rd_en;
            out_done  <= rd_en && last_read;
        end
    end

endmodule

// File: rtl/up2x_row.sv
// Top of the 2x nearest-neighbour upsampler for one channel. Connects the
// write controller, the RAM and the read controller. Assumes the source
// paces its input so writes never overtake rows still being replayed.
module up2x_row #(
    parameter int ELEM_W    = 8,
    parameter int IMG_W     = 8,
    parameter int IMG_H     = 8,
    parameter int RAM_DEPTH = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic [ELEM_W-1:0] in_data,
    input  logic              in_valid,
    output logic [ELEM_W-1:0] out_data,
    output logic              out_valid,
    output logic              out_done
);

    localparam int ADDR_W = $clog2(RAM_DEPTH);
    localparam int ROW_W  = $clog2(IMG_H + 1);

    logic              we;
    logic [ADDR_W-1:0] wr_addr;
    logic [ROW_W-1:0]  rows_written;
    logic              first_row;
    logic              rd_en;
    logic [ADDR_W-1:0] rd_addr;
    logic [ROW_W-1:0]  rd_row;

    up2x_wr_ctrl #(
        .IMG_W (IMG_W),
        .IMG_H (IMG_H),
        .DEPTH (RAM_DEPTH)
    ) u_wr (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear        (clear),
        .in_valid     (in_valid),
        .we           (we),
        .wr_addr      (wr_addr),
        .rows_written (rows_written),
        .first_row    (first_row)
    );

    up2x_ram #(
        .DATA_W (ELEM_W),
        .DEPTH  (RAM_DEPTH)
    ) u_ram (
        .clk   (clk),
        .we    (we),
        .waddr (wr_addr),
        .wdata (in_data),
        .re    (rd_en),
        .raddr (rd_addr),
        .rdata (out_data)
    );

    up2x_rd_ctrl #(
        .IMG_W (IMG_W),
        .IMG_H (IMG_H),
        .DEPTH (RAM_DEPTH)
    ) u_rd (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear        (clear),
        .first_row    (first_row),
        .rows_written (rows_written),
        .rd_en        (rd_en),
        .rd_addr      (rd_addr),
        .rd_row       (rd_row),
        .out_valid    (out_valid),
        .out_done     (out_done)
    );

endmodule

// File: rtl/up2x_chk.sv
// Property checker for up2x_row, attached by bind. Observes ports and the
// signals passed between the write and read controllers.
module up2x_chk #(
    parameter int IMG_H  = 8,
    parameter int ADDR_W = 6,
    parameter int ROW_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clear,
    input logic              in_valid,
    input logic              out_valid,
    input logic              out_done,
    input logic              rd_en,
    input logic [ROW_W-1:0]  rows_written,
    input logic [ADDR_W-1:0] wr_addr
);

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_done |=> !out_done);

    // R6
    done_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_done |-> out_valid);

    // R5
    done_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_done |-> (rows_written == ROW_W'(IMG_H)));

    // R11
    read_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !clear) |=> out_valid);

    // R7
    clear_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (!out_valid && !out_done));

    // R8
    full_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !clear && rows_written == ROW_W'(IMG_H)) |=> $stable(wr_addr));

endmodule

bind up2x_row up2x_chk #(
    .IMG_H  (IMG_H),
    .ADDR_W (ADDR_W),
    .ROW_W  (ROW_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .clear        (clear),
    .in_valid     (in_valid),
    .out_valid    (out_valid),
    .out_done     (out_done),
    .rd_en        (rd_en),
    .rows_written (rows_written),
    .wr_addr      (wr_addr)
);

// File: tb/sim_up2x_row.sv
// Scoreboard bench: the driver queues the expected upscaled stream, the
// monitor compares every valid output against the queue.
module sim_up2x_row;

    localparam int W  = 4;
    localparam int H  = 6;
    localparam int D  = 16;
    localparam int EW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clear = 1'b0;
    logic [EW-1:0] in_data = '0;
    logic          in_valid = 1'b0;
    logic [EW-1:0] out_data;
    logic          out_valid;
    logic          out_done;

    int n_chk  = 0;
    int n_fail = 0;
    int vcount = 0;
    int done_cnt = 0;
    bit mon_en = 1'b0;
    logic [EW-1:0] exp_q[$];

    always #10 clk = ~clk;

    up2x_row #(.ELEM_W(EW), .IMG_W(W), .IMG_H(H), .RAM_DEPTH(D)) u0 (
        .clk(clk), .rst_n(rst_n), .clear(clear), .in_data(in_data),
        .in_valid(in_valid), .out_data(out_data), .out_valid(out_valid),
        .out_done(out_done)
    );

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Monitor: compare outputs against the expected queue
    always @(negedge clk) begin
        if (rst_n && out_valid) vcount++;
        if (rst_n && mon_en) begin
            if (out_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R1 R8", "unexpected output", int'(out_data), -1);
                end else begin
                    logic [EW-1:0] e;
                    e = exp_q.pop_front();
                    check(out_data == e, "R2 R3 R9", "output element",
                          int'(out_data), int'(e));
                end
            end
            if (out_done) begin
                done_cnt++;
                check(out_valid && exp_q.size() == 0, "R6", "done with last item",
                      exp_q.size(), 0);
            end
        end
    end

    function automatic int gap_of(int mode, int c);
        if (mode == 0) return 3;
        if (mode == 1) return (c == W - 1) ? 12 : 0;
        return 9;
    endfunction

    task automatic do_clear();
        @(negedge clk) clear = 1'b1;
        @(negedge clk) clear = 1'b0;
    endtask

    // Driver: queue expected upscaled frame, then drive the input frame
    task automatic send_frame(int base, int mode, bit lat, bit push);
        if (push) begin
            for (int r = 0; r < H; r++)
                for (int rr = 0; rr < 2; rr++)
                    for (int c = 0; c < W; c++)
                        for (int cc = 0; cc < 2; cc++)
                            exp_q.push_back(EW'(base + r * W + c));
        end
        for (int r = 0; r < H; r++) begin
            for (int c = 0; c < W; c++) begin
                @(negedge clk);
                in_valid = 1'b1;
                in_data  = EW'(base + r * W + c);
                for (int g = 0; g < gap_of(mode, c); g++) begin
                    @(negedge clk);
                    in_valid = 1'b0;
                    if (lat && r == 0 && c == W - 1 && g == 0)
                        check(!out_valid, "R11", "valid one edge after row", int'(out_valid), 0);
                    if (lat && r == 0 && c == W - 1 && g == 1)
                        check(out_valid, "R11", "valid two edges after row", int'(out_valid), 1);
                end
            end
        end
        @(negedge clk) in_valid = 1'b0;
    endtask

    task automatic drain();
        int t = 0;
        while (exp_q.size() != 0 && t < 3000) begin
            @(negedge clk);
            t++;
        end
        check(exp_q.size() == 0, "R1", "items left in queue", exp_q.size(), 0);
        repeat (6) @(negedge clk);
    endtask

    task automatic frame(int base, int mode, bit lat, string tag);
        do_clear();
        done_cnt = 0;
        send_frame(base, mode, lat, 1'b1);
        drain();
        check(done_cnt == 1, tag, "done pulses in frame", done_cnt, 1);
    endtask

    initial begin
        int v0;
        repeat (3) @(negedge clk);
        // R10 reset state
        check(!out_valid, "R10", "valid in reset", int'(out_valid), 0);
        check(!out_done, "R10", "done in reset", int'(out_done), 0);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        check(!out_valid && !out_done, "R10", "outputs after reset",
              int'(out_valid) + int'(out_done), 0);
        mon_en = 1'b1;

        // R1 R9 R11: bursty rows, first-output latency
        frame(10, 1, 1'b1, "R6");

        // R8: extra elements after a full frame are ignored
        v0 = vcount;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk) in_valid = 1'b1;
            in_data = EW'(i);
        end
        @(negedge clk) in_valid = 1'b0;
        repeat (30) @(negedge clk);
        check(vcount == v0, "R8", "outputs after full frame", vcount - v0, 0);

        // R2 R3: steady pacing
        frame(40, 0, 1'b0, "R6");
        // R5: slow input forcing read stalls
        frame(100, 2, 1'b0, "R5");

        // R4: partial first row gives no output
        do_clear();
        v0 = vcount;
        for (int i = 0; i < W - 1; i++) begin
            @(negedge clk) in_valid = 1'b1;
            in_data = EW'(i);
        end
        @(negedge clk) in_valid = 1'b0;
        repeat (20) @(negedge clk);
        check(vcount == v0, "R4", "outputs before first row", vcount - v0, 0);

        // R7: abort a frame midway, then a fresh frame must be correct
        mon_en = 1'b0;
        do_clear();
        for (int i = 0; i < 2 * W; i++) begin
            @(negedge clk) in_valid = 1'b1;
            in_data = EW'(7 * i);
        end
        @(negedge clk) in_valid = 1'b0;
        repeat (4) @(negedge clk);
        check(out_valid, "R7", "stream running before clear", int'(out_valid), 1);
        @(negedge clk) clear = 1'b1;
        @(negedge clk) clear = 1'b0;
        check(!out_valid && !out_done, "R7", "outputs after clear",
              int'(out_valid) + int'(out_done), 0);
        exp_q.delete();
        mon_en = 1'b1;
        frame(200, 0, 1'b0, "R7");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule